// File: doc/BRIEF.md
# Addressed Four-Wire Register Interface

This block is the serial slave that an external host controller uses to reach a small bank of 8-bit control registers over four wires: an active-low select, a serial clock, a data line into the block and a data line out of it. Each access is a 16-bit frame. Seven address bits come first, least significant bit first. A direction bit follows, where 0 writes and 1 reads. Eight data bits close the frame, again least significant bit first. Several frames may follow one another while the select stays low.

The returned data line has a separate enable, so the pad can leave it floating. It is enabled only while the eight data bits of a read from a readable address are being shifted out. Several devices can therefore share one select line. A selection register carries an enable bit and a 4-bit identity. When the enable bit is set, the device serves only accesses whose identity matches its four strap pins. Writes to the selection register itself are always accepted, so a broadcast write at the start of a select window picks the target device.

The registers behind the interface are the direction and output value of a bank of general-purpose port pins, a read-only snapshot of those pins, and a fixed identification byte. The four serial inputs, the strap pins and the port pins are resynchronised to the system clock. Bits are taken on the rising serial-clock edge. Read data changes after the falling edge.

Top module: `quad_wire_regif`

## Requirements
- R1: A frame carries address bits 0..6, then the direction bit (0 = write, 1 = read), then data bits 0..7, each taken on a rising serial-clock edge while select is low; a write stores the data byte in the addressed register.
- R2: `so_en` is high only during the eight data bit periods of a read, and changes after a falling serial-clock edge; it is low during the address and direction bits, after the frame, and whenever select is high.
- R3: Addresses 0x18..0x1F and 0x40..0x7E are invalid: a read of them leaves `so_en` low for the whole frame, and a write to them changes no output.
- R4: Address 0x7F reads the fixed identification byte 0x02; writes to it are ignored.
- R5: Register 0x00 holds the selection enable in bit 4 and the device identity in bits 3..0, with bits 7..5 reading 0. With the enable set and the identity unequal to `strap_id`, reads leave `so_en` low and writes to any other register are ignored.
- R6: Writes to register 0x00 are accepted whether or not the identity matches, and several frames may be sent back to back under one select-low window, so a leading write to 0x00 chooses the device for the frames that follow.
- R7: The port pins are sampled at the rising edge of the direction bit. A read of the input registers 0x07 (pins 7..0), 0x08 (pins 15..8) and 0x09 (pins 19..16 in bits 3..0) returns that sample, unaffected by later pin changes in the same frame.
- R8: A write takes effect only at the rising edge of data bit 7, the sixteenth edge of the frame. Direction registers are 0x01..0x03 and output registers are 0x04..0x06, each covering pins 7..0, 15..8 and 19..16 in that order, with 1 in a direction bit marking an output pin.
- R9: Select going high in mid-frame drops the partial frame without effect and restarts bit counting, so the next frame is decoded from its first bit.
- R10: After reset `port_dir`, `port_out` and register 0x00 are zero and `so_en` is low.
- R11: Readable addresses without a register here (0x0A..0x17 and 0x20..0x3F) drive `so_en` during the data bits and return 0x00; writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| strap_id | input | 4 | Strap pins giving this device's identity |
| port_in | input | PORT_W | Sampled levels of the general-purpose pins |
| so_q | output | 1 | Serial read data toward the host |
| so_en | output | 1 | Drive enable for `so_q`; the pad floats when low |
| port_dir | output | PORT_W | Pin direction, 1 = output |
| port_out | output | PORT_W | Value driven on the output pins |

## Verification
The assertions assume that each serial-clock phase lasts longer than the synchroniser depth plus two system clocks, so that every edge is seen once. They also assume that select changes only while the serial clock is low, and that the pins are steady for a few clocks around the direction bit. The bench holds every phase for eight system clocks, moves select only with the serial clock low, and changes the pins either well before a frame or a full phase after the direction edge. It sweeps reads over all 128 addresses and writes over the valid and invalid ranges, under matching and mismatching identities.

// File: rtl/qwr_pkg.sv
// Shared constants and address decoding for the four-wire register interface.
// Assumes a 7-bit address space, 8-bit registers and at most 24 port pins
// (three register bytes per port group).
package qwr_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int ID_W       = 4;
    localparam int SEL_EN_BIT = 4;

    localparam logic [ADDR_W-1:0] SEL_ADDR = 7'h00;
    localparam logic [ADDR_W-1:0] DIR_BASE = 7'h01;
    localparam logic [ADDR_W-1:0] OUT_BASE = 7'h04;
    localparam logic [ADDR_W-1:0] IN_BASE  = 7'h07;
    localparam logic [ADDR_W-1:0] ID_ADDR  = 7'h7F;
    localparam logic [DATA_W-1:0] DEVICE_ID = 8'h02;

    // True for any address whose read drives the return line.
    function automatic logic addr_readable(input logic [ADDR_W-1:0] a);
        return !((a >= 7'h18 && a <= 7'h1F) || (a >= 7'h40 && a <= 7'h7E));
    endfunction
endpackage

// File: rtl/qwr_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is sampled independently (no multi-bit coherence).
module qwr_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qwr_frame.sv
// Frame engine: counts serial bits, assembles address, direction and data,
// latches the read byte at the direction edge and shifts it out on falling
// edges. Assumes synchronised inputs whose phases exceed two clocks.
module qwr_frame
    import qwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              match,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rw_q,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_commit,
    output logic              so_q,
    output logic              so_en
);
    localparam int FRAME = ADDR_W + 1 + DATA_W;
    localparam int CW    = $clog2(FRAME);
    localparam int AIW   = $clog2(ADDR_W);
    localparam int DIW   = $clog2(DATA_W);
    localparam logic [CW-1:0] RW_POS   = CW'(ADDR_W);
    localparam logic [CW-1:0] LAST_POS = CW'(FRAME - 1);

    logic              sck_d;
    logic              rise;
    logic              fall;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rd_latch;
    logic              rd_drive;
    logic [DIW-1:0]    didx;

    assign rise = sck_s & ~sck_d & ~cs_n_s;
    assign fall = ~sck_s & sck_d & ~cs_n_s;
    assign didx = DIW'(cnt - RW_POS - CW'(1));

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Count bits and assemble the address, direction and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            addr_q    <= '0;
            rw_q      <= 1'b0;
            shreg     <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
            rd_latch  <= '0;
            rd_drive  <= 1'b0;
        end else begin
            wr_commit <= 1'b0;
            if (cs_n_s) begin
                cnt      <= '0;
                rd_drive <= 1'b0;
            end else if (rise) begin
                if (cnt < RW_POS) begin
                    addr_q[cnt[AIW-1:0]] <= si_s;
                end else if (cnt == RW_POS) begin
                    rw_q     <= si_s;
                    rd_latch <= rd_byte;
                    rd_drive <= si_s & addr_readable(addr_q) & match;
                end else begin
                    shreg[didx] <= si_s;
                end
                if (cnt == LAST_POS) begin
                    cnt       <= '0;
                    wr_data   <= {si_s, shreg[DATA_W-2:0]};
                    wr_commit <= ~rw_q;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // Drive read data after each falling edge of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so_en <= 1'b0;
            so_q  <= 1'b0;
        end else if (cs_n_s) begin
            so_en <= 1'b0;
        end else if (fall) begin
            if (rd_drive && cnt > RW_POS) begin
                so_en <= 1'b1;
                so_q  <= rd_latch[didx];
            end else begin
                so_en <= 1'b0;
            end
        end
    end

    p_quiet_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_en);
    p_enable_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_en) |-> $past(fall));
    p_drive_readable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> addr_readable(addr_q));
    p_commit_write_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !rw_q);
endmodule

// File: rtl/qwr_bank.sv
// Register bank: selection register, port direction and output registers,
// input snapshot readout and the identification byte. Assumes PORT_W <= 24.
module qwr_bank
    import qwr_pkg::*;
#(
    parameter int PORT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_commit,
    input  logic              match,
    input  logic [PORT_W-1:0] port_s,
    output logic              sel_en,
    output logic [ID_W-1:0]   sel_id,
    output logic [PORT_W-1:0] port_dir,
    output logic [PORT_W-1:0] port_out,
    output logic [DATA_W-1:0] rd_byte
);
    localparam int NB = (PORT_W + DATA_W - 1) / DATA_W;
    localparam int PW = NB * DATA_W;

    logic [SEL_EN_BIT:0] sel_q;
    logic [PW-1:0]       dir_nx;
    logic [PW-1:0]       out_nx;
    logic [PW-1:0]       dir_pad;
    logic [PW-1:0]       out_pad;
    logic [PW-1:0]       in_pad;
    logic                wr_ok;

    assign sel_en = sel_q[SEL_EN_BIT];
    assign sel_id = sel_q[ID_W-1:0];
    assign wr_ok  = wr_commit & match;

    // Zero-extend the port vectors to whole register bytes.
    always_comb begin
        dir_pad = '0;
        out_pad = '0;
        in_pad  = '0;
        dir_pad[PORT_W-1:0] = port_dir;
        out_pad[PORT_W-1:0] = port_out;
        in_pad[PORT_W-1:0]  = port_s;
    end

    // Merge an accepted write into the port register images.
    always_comb begin
        dir_nx = dir_pad;
        out_nx = out_pad;
        for (int k = 0; k < NB; k++) begin
            if (wr_ok && addr == ADDR_W'(DIR_BASE + k)) dir_nx[k*DATA_W +: DATA_W] = wr_data;
            if (wr_ok && addr == ADDR_W'(OUT_BASE + k)) out_nx[k*DATA_W +: DATA_W] = wr_data;
        end
    end

    // Hold the selection and port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            port_dir <= '0;
            port_out <= '0;
        end else begin
            if (wr_commit && addr == SEL_ADDR) sel_q <= wr_data[SEL_EN_BIT:0];
            port_dir <= dir_nx[PORT_W-1:0];
            port_out <= out_nx[PORT_W-1:0];
        end
    end

    // Select the byte returned for the current address.
    always_comb begin
        rd_byte = '0;
        if (addr == SEL_ADDR) rd_byte = DATA_W'(sel_q);
        if (addr == ID_ADDR)  rd_byte = DEVICE_ID;
        for (int k = 0; k < NB; k++) begin
            if (addr == ADDR_W'(DIR_BASE + k)) rd_byte = dir_pad[k*DATA_W +: DATA_W];
            if (addr == ADDR_W'(OUT_BASE + k)) rd_byte = out_pad[k*DATA_W +: DATA_W];
            if (addr == ADDR_W'(IN_BASE + k))  rd_byte = in_pad[k*DATA_W +: DATA_W];
        end
    end

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(port_out) && $stable(port_dir));
    p_mismatch_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !match && addr != SEL_ADDR) |=> $stable(port_out) && $stable(port_dir));
endmodule

// File: rtl/quad_wire_regif.sv
// Top of the four-wire register interface: synchronises the host lines,
// strap pins and port pins, and joins the frame engine to the register bank.
// Assumes the host serial clock is much slower than clk.
module quad_wire_regif
    import qwr_pkg::*;
#(
    parameter int PORT_W      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic [ID_W-1:0]   strap_id,
    input  logic [PORT_W-1:0] port_in,
    output logic              so_q,
    output logic              so_en,
    output logic [PORT_W-1:0] port_dir,
    output logic [PORT_W-1:0] port_out
);
    logic              cs_n_s, sck_s, si_s;
    logic [ID_W-1:0]   strap_s;
    logic [PORT_W-1:0] port_s;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic [DATA_W-1:0] wr_data;
    logic              wr_commit;
    logic [DATA_W-1:0] rd_byte;
    logic              sel_en;
    logic [ID_W-1:0]   sel_id;
    logic              match;

    qwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_host_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q({cs_n_s, sck_s, si_s}));
    qwr_sync #(.WIDTH(ID_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_strap_sync (
        .clk(clk), .rst_n(rst_n), .d(strap_id), .q(strap_s));
    qwr_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_port_sync (
        .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s));

    assign match = ~sel_en | (sel_id == strap_s);

    qwr_frame i_frame (
        .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s), .si_s(si_s),
        .match(match), .rd_byte(rd_byte), .addr_q(addr_q), .rw_q(rw_q),
        .wr_data(wr_data), .wr_commit(wr_commit), .so_q(so_q), .so_en(so_en));

    qwr_bank #(.PORT_W(PORT_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr_q), .wr_data(wr_data),
        .wr_commit(wr_commit), .match(match), .port_s(port_s),
        .sel_en(sel_en), .sel_id(sel_id), .port_dir(port_dir),
        .port_out(port_out), .rd_byte(rd_byte));
endmodule

// File: tb/test_quad_wire_regif.sv
module test_quad_wire_regif;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int PW         = 20;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic [3:0]    strap_id = 4'h3;
    logic [PW-1:0] port_in = '0;
    logic          so_q, so_en;
    logic [PW-1:0] port_dir, port_out;

    quad_wire_regif #(.PORT_W(PW), .SYNC_STAGES(2)) i_quad_wire_regif (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .strap_id(strap_id), .port_in(port_in), .so_q(so_q), .so_en(so_en),
        .port_dir(port_dir), .port_out(port_out));

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0]    got;
    int            drv_cnt;
    bit            early, late;
    logic [PW-1:0] out15;
    logic [4:0]    m_sel = '0;
    logic [PW-1:0] m_dir = '0, m_out = '0;

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit matched();
        return !m_sel[4] || (m_sel[3:0] == strap_id);
    endfunction

    function automatic bit readable(logic [6:0] a);
        return !((a >= 7'h18 && a <= 7'h1F) || (a >= 7'h40 && a <= 7'h7E));
    endfunction

    function automatic logic [7:0] exp_rd(logic [6:0] a);
        logic [23:0] d = {4'h0, m_dir};
        logic [23:0] o = {4'h0, m_out};
        logic [23:0] p = {4'h0, port_in};
        if (a == 7'h00) return {3'b000, m_sel};
        if (a == 7'h7F) return 8'h02;
        if (a >= 7'h01 && a <= 7'h03) return d[(a-1)*8 +: 8];
        if (a >= 7'h04 && a <= 7'h06) return o[(a-4)*8 +: 8];
        if (a >= 7'h07 && a <= 7'h09) return p[(a-7)*8 +: 8];
        return 8'h00;
    endfunction

    task automatic model_wr(logic [6:0] a, logic [7:0] v);
        logic [23:0] t;
        if (a == 7'h00) m_sel = v[4:0];
        else if (matched() && a >= 7'h01 && a <= 7'h03) begin
            t = {4'h0, m_dir}; t[(a-1)*8 +: 8] = v; m_dir = t[PW-1:0];
        end else if (matched() && a >= 7'h04 && a <= 7'h06) begin
            t = {4'h0, m_out}; t[(a-4)*8 +: 8] = v; m_out = t[PW-1:0];
        end
    endtask

    task automatic frame(logic [6:0] a, logic rw, logic [7:0] wd, bit chg, logic [PW-1:0] cv);
        logic [15:0] bits = {wd, rw, a};
        early = 0; drv_cnt = 0; got = '0;
        for (int i = 0; i < 16; i++) begin
            si = bits[i];
            if (chg && i == 8) port_in = cv;
            tick(HALF);
            if (i < 8) early |= so_en;
            else begin
                if (so_en) drv_cnt++;
                got[i-8] = so_q;
            end
            if (i == 15) out15 = port_out;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        tick(HALF);
        late = so_en;
    endtask

    task automatic cs_lo();
        cs_n = 1'b0; tick(HALF);
    endtask
    task automatic cs_hi();
        cs_n = 1'b1; tick(HALF);
    endtask

    task automatic xact(logic [6:0] a, logic rw, logic [7:0] wd);
        cs_lo(); frame(a, rw, wd, 1'b0, '0); cs_hi();
    endtask

    task automatic do_write(logic [6:0] a, logic [7:0] v, string tag);
        xact(a, 1'b0, v);
        model_wr(a, v);
        chk(port_out == m_out, tag, 32'(port_out), 32'(m_out));
        chk(port_dir == m_dir, tag, 32'(port_dir), 32'(m_dir));
    endtask

    task automatic do_read(logic [6:0] a, string tag);
        bit exp_drive = readable(a) && matched();
        xact(a, 1'b1, 8'h00);
        if (exp_drive) begin
            chk(drv_cnt == 8 && !early && !late, {tag, " drive"}, 32'(drv_cnt), 32'd8);
            chk(got == exp_rd(a), {tag, " data"}, 32'(got), 32'(exp_rd(a)));
        end else begin
            chk(drv_cnt == 0 && !early && !late, {tag, " float"}, 32'(drv_cnt), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] old;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R10: reset state
        chk(port_out == '0, "R10 port_out", 32'(port_out), 0);
        chk(port_dir == '0, "R10 port_dir", 32'(port_dir), 0);
        chk(so_en == 1'b0, "R10 so_en", 32'(so_en), 0);
        do_read(7'h00, "R10 sel reg");

        // R1/R8: write port registers and read them back
        do_write(7'h04, 8'hA5, "R1 out lo");
        do_write(7'h05, 8'h3C, "R1 out mid");
        do_write(7'h06, 8'hF9, "R8 out hi");
        chk(port_out == 20'h93CA5, "R8 out map", 32'(port_out), 32'h93CA5);
        do_write(7'h01, 8'h0F, "R8 dir lo");
        do_write(7'h02, 8'hE1, "R8 dir mid");
        do_write(7'h03, 8'h5C, "R8 dir hi");
        chk(port_dir == 20'hCE10F, "R8 dir map", 32'(port_dir), 32'hCE10F);

        // R2/R3/R4/R11/R7: read sweep over every address
        port_in = 20'hB7E29;
        tick(HALF);
        for (int a = 0; a < 128; a++) do_read(7'(a), "R3 sweep");

        // R3/R4/R11: writes to invalid, fixed and read-only addresses change nothing
        do_write(7'h18, 8'hFF, "R3 write 18");
        do_write(7'h1F, 8'hFF, "R3 write 1F");
        do_write(7'h40, 8'hFF, "R3 write 40");
        do_write(7'h7E, 8'hFF, "R3 write 7E");
        do_write(7'h7F, 8'hFF, "R4 write 7F");
        do_write(7'h07, 8'hFF, "R7 write in");
        do_write(7'h11, 8'hFF, "R11 write 11");
        do_write(7'h2A, 8'hFF, "R11 write 2A");
        do_read(7'h7F, "R4 id");
        do_read(7'h2A, "R11 zero");

        // R8: the output changes only at the sixteenth edge
        old = port_out;
        cs_lo(); frame(7'h04, 1'b0, 8'h5A, 1'b0, '0); cs_hi();
        model_wr(7'h04, 8'h5A);
        chk(out15 == old, "R8 before D7", 32'(out15), 32'(old));
        chk(port_out == m_out, "R8 after D7", 32'(port_out), 32'(m_out));

        // R7: pins changed after the direction bit do not alter the byte
        port_in = 20'h1234C;
        tick(HALF);
        cs_lo(); frame(7'h07, 1'b1, 8'h00, 1'b1, 20'h55AB3); cs_hi();
        chk(got == 8'h4C, "R7 snapshot", 32'(got), 32'h4C);
        do_read(7'h07, "R7 new pins");

        // R9: a partial frame is dropped and the next one is aligned
        old = port_out;
        cs_lo();
        for (int i = 0; i < 10; i++) begin
            logic [15:0] b = {8'hFF, 1'b0, 7'h04};
            si = b[i]; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
        end
        cs_hi();
        chk(port_out == old, "R9 abort", 32'(port_out), 32'(old));
        do_read(7'h04, "R9 realign");
        do_write(7'h05, 8'h81, "R9 realign write");

        // R5: matching identity keeps access, mismatching identity blocks it
        do_write(7'h00, 8'hF3, "R5 sel match");
        do_read(7'h00, "R5 sel read");
        do_write(7'h04, 8'h66, "R5 match write");
        do_write(7'h00, 8'h15, "R6 sel mismatch");
        do_write(7'h04, 8'h99, "R5 blocked write");
        do_write(7'h02, 8'h99, "R5 blocked dir");
        do_read(7'h04, "R5 blocked read");
        do_read(7'h7F, "R5 blocked id");

        // R6: broadcast select write then a write in the same select window
        cs_lo();
        frame(7'h00, 1'b0, 8'h13, 1'b0, '0); model_wr(7'h00, 8'h13);
        frame(7'h05, 1'b0, 8'hC3, 1'b0, '0); model_wr(7'h05, 8'hC3);
        cs_hi();
        chk(port_out == m_out, "R6 window write", 32'(port_out), 32'(m_out));
        do_read(7'h05, "R6 readback");
        do_write(7'h00, 8'h00, "R6 clear sel");
        do_read(7'h00, "R6 sel zero");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule